// File: doc/BRIEF.md
# NAND Page Read Command Sequencer

This block runs the command phase of a single page read on a raw NAND flash bus. On a start pulse it captures a page index and a set of mode bits. It then waits for the device to become idle, sends the read setup command and the address bytes, and sends the confirm command. It then waits for the array-to-register transfer to finish. When it is done, the device is left in data-output mode, ready for a separate burst engine to fetch the page bytes.

Readiness is taken from one of two sources. In pin mode the block watches the ready/busy line, which is high when the device is ready. In polling mode it sends status-read commands, separated by a programmable idle gap, and watches the ready bit of the returned status byte. A single-plane device gets the plain status command. A multi-plane device gets the enhanced variant, followed by the page's row bytes. Any status read switches the device to status output, so a read-mode command is sent before the block hands over. When device ECC checking is on, the status pass/fail bit is evaluated and a failure is reported. A wait that exceeds a programmable cycle limit aborts the read with a timeout code.

The bus is modelled at one cycle per phase:
- a command cycle drives the command latch and the write strobe;
- an address cycle drives the address latch and the write strobe;
- a read cycle drives the read strobe and samples the input byte at the end of that cycle.

Top module: `nand_page_read_seq`

## Requirements
- R1: During and after reset, `busy`, `done` and `err_code` are 0 and no bus strobe (`nf_cle`, `nf_ale`, `nf_we`, `nf_re`) is asserted. No strobe is ever asserted while `busy` is 0.
- R2: The setup command (00h) is never sent while the device is busy. In pin mode the block waits for `nf_ready` = 1. In polling mode it waits for a status byte with bit 6 = 1.
- R3: In pin mode (`poll_mode` = 0), completion is taken from `nf_ready` alone. No status command is sent, except the single ECC status read when `ecc_chk` = 1.
- R4: In polling mode, status reads repeat until bit 6 of the status byte is 1, both before the setup command and after the confirm command. With `multi_plane` = 0 the status opcode is 70h.
- R5: With `multi_plane` = 1 the status opcode is 78h. It is followed by three address cycles that carry the page index, least significant byte first, before the status byte is read.
- R6: After ready, the block sends 00h, then five address bytes, then 30h. The five address bytes form the value page_idx shifted left by 16 column bits, least significant byte first.
- R7: When any status read has taken place after the confirm command (polling mode, or `ecc_chk` = 1), a read-mode command 00h is sent as the last bus cycle before `done`. In pin mode without ECC no read-mode command is sent.
- R8: With `ecc_chk` = 1, status bit 0 = 1 gives `err_code` = 2 (ECC fail). With `ecc_chk` = 0, bit 0 is ignored and a normal read ends with `err_code` = 0.
- R9: If a wait lasts `wait_limit` cycles without ready, the read ends with `done` and `err_code` = 1 (timeout), and no read-mode command is sent.
- R10: In polling mode, after a status read that reports busy, the next status command follows exactly `poll_gap` + 2 cycles after that read cycle.
- R11: `done` is a one-cycle pulse, `busy` is 0 from that cycle on, and `err_code` changes only in the cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to start a page read (taken while idle) |
| page_idx | input | 24 | Page index (row address) |
| poll_mode | input | 1 | 1: status polling, 0: ready/busy pin |
| ecc_chk | input | 1 | Evaluate the device ECC pass/fail status bit |
| multi_plane | input | 1 | Use the enhanced status command with row bytes |
| poll_gap | input | 8 | Idle cycles between status reads, minus one |
| wait_limit | input | 20 | Cycles a wait may last before timeout |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 ECC fail; updated with done |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we | output | 1 | Write strobe for command/address cycles |
| nf_re | output | 1 | Read strobe for status cycles |
| nf_dq_out | output | 8 | Command or address byte |
| nf_dq_in | input | 8 | Byte returned by the device on a read cycle |
| nf_ready | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The bench drives a small device model. The model goes busy on the confirm command, stays busy for a chosen time, and records every bus cycle. The bench then checks the recorded sequence against each mode combination.

The corner cases it targets, and what a faulty design would do in each:
- Device busy at start: a design that skips the pre-wait sends the setup command while busy.
- Leaving status output: a design that forgets the read-mode command leaves the device in status output.
- Mode mixing: a design that mixes up the modes either sends status commands in pin mode or ignores the status byte.
- Multi-plane status: a design with wrong row-byte order sends a bad enhanced status address.
- ECC bit: a design that evaluates bit 0 without ECC enabled reports false ECC errors.
- Timeout: with a stuck busy device, a design without the timeout never finishes.
- Poll spacing: a miscounted gap shows up as wrong spacing between polls.

// File: rtl/nrs_pkg.sv
// Package: shared state types, opcodes and result codes of the page read sequencer.
package nrs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE_RB,
        S_STAT_CMD,
        S_STAT_ADDR,
        S_STAT_RD,
        S_GAP,
        S_SETUP,
        S_ADDR,
        S_CONF,
        S_POST_RB,
        S_MODE
    } seq_state_t;

    typedef enum logic [1:0] {
        STG_PRE,
        STG_POST,
        STG_ECC
    } wait_stage_t;

    localparam logic [7:0] OP_SETUP      = 8'h00;
    localparam logic [7:0] OP_CONFIRM    = 8'h30;
    localparam logic [7:0] OP_STATUS     = 8'h70;
    localparam logic [7:0] OP_STATUS_ENH = 8'h78;
    localparam logic [7:0] OP_DATA_OUT   = 8'h00;

    localparam int SR_RDY_BIT  = 6;
    localparam int SR_FAIL_BIT = 0;

    localparam logic [1:0] ERR_NONE    = 2'd0;
    localparam logic [1:0] ERR_TIMEOUT = 2'd1;
    localparam logic [1:0] ERR_ECC     = 2'd2;

endpackage

// File: rtl/nrs_addr_bytes.sv
// Module: nrs_addr_bytes
// Forms the address bytes for the setup command and the row bytes for the
// enhanced status command, both from the page index, least significant byte first.
// Assumes: the column field is COL_W bits, rounded up to whole bytes on the bus,
// and it is sent as zero.
module nrs_addr_bytes #(
    parameter int COL_W     = 16,
    parameter int ROW_BYTES = 3,
    parameter int IDX_W     = 3
) (
    input  logic [ROW_BYTES*8-1:0] page,
    input  logic [IDX_W-1:0]       idx,
    output logic [7:0]             setup_byte,
    output logic [7:0]             row_byte
);
    localparam int COL_BYTES  = (COL_W + 7) / 8;
    localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
    localparam int ADDR_W     = ADDR_BYTES * 8;

    logic [ADDR_W-1:0] full_addr;
    logic [7:0]        setup_arr [ADDR_BYTES];
    logic [7:0]        row_arr   [ROW_BYTES];

    assign full_addr = ADDR_W'(page) << COL_W;

    generate
        for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_setup
            assign setup_arr[g] = full_addr[8*g +: 8];
        end
        for (genvar h = 0; h < ROW_BYTES; h++) begin : g_row
            assign row_arr[h] = page[8*h +: 8];
        end
    endgenerate

    // Select the setup address byte for the current index.
    always_comb begin
        setup_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == IDX_W'(k)) setup_byte = setup_arr[k];
        end
    end

    // Select the status row byte for the current index.
    always_comb begin
        row_byte = '0;
        for (int k = 0; k < ROW_BYTES; k++) begin
            if (idx == IDX_W'(k)) row_byte = row_arr[k];
        end
    end

endmodule

// File: rtl/nrs_wait_timer.sv
// Module: nrs_wait_timer
// Holds the wait timeout counter and the poll gap down-counter.
// Assumes: to_clr takes priority over to_run, and gap_load over the countdown.
module nrs_wait_timer #(
    parameter int IV_W = 8,
    parameter int TO_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            to_clr,
    input  logic            to_run,
    input  logic [TO_W-1:0] to_lim,
    output logic            to_hit,
    input  logic            gap_load,
    input  logic [IV_W-1:0] gap_val,
    output logic            gap_done
);
    logic [TO_W-1:0] to_cnt;
    logic [IV_W-1:0] gap_cnt;

    assign to_hit   = (to_cnt >= to_lim);
    assign gap_done = (gap_cnt == '0);

    // Count the cycles spent waiting, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                to_cnt <= '0;
        else if (to_clr)           to_cnt <= '0;
        else if (to_run && !to_hit) to_cnt <= to_cnt + 1'b1;
    end

    // Count down the idle gap between status polls.
    always_ff @(posedge clk) begin
        if (!rst_n)            gap_cnt <= '0;
        else if (gap_load)     gap_cnt <= gap_val;
        else if (!gap_done)    gap_cnt <= gap_cnt - 1'b1;
    end

    assert_gap_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gap_load |=> (gap_cnt == $past(gap_val)));

endmodule

// File: rtl/nrs_bus_decode.sv
// Module: nrs_bus_decode
// Maps the sequencer state to one bus cycle: latch enables, strobes and byte.
// Assumes: each state lasts exactly one bus cycle, except the wait states,
// which drive nothing.
module nrs_bus_decode import nrs_pkg::*; (
    input  seq_state_t st,
    input  logic       multi,
    input  logic [7:0] setup_byte,
    input  logic [7:0] row_byte,
    output logic       cle,
    output logic       ale,
    output logic       we,
    output logic       re,
    output logic [7:0] dq
);
    // Decode the current phase into pin levels.
    always_comb begin
        cle = 1'b0;
        ale = 1'b0;
        we  = 1'b0;
        re  = 1'b0;
        dq  = 8'h00;
        case (st)
            S_STAT_CMD: begin
                cle = 1'b1;
                we  = 1'b1;
                dq  = multi ? OP_STATUS_ENH : OP_STATUS;
            end
            S_STAT_ADDR: begin
                ale = 1'b1;
                we  = 1'b1;
                dq  = row_byte;
            end
            S_STAT_RD: re = 1'b1;
            S_SETUP: begin
                cle = 1'b1;
                we  = 1'b1;
                dq  = OP_SETUP;
            end
            S_ADDR: begin
                ale = 1'b1;
                we  = 1'b1;
                dq  = setup_byte;
            end
            S_CONF: begin
                cle = 1'b1;
                we  = 1'b1;
                dq  = OP_CONFIRM;
            end
            S_MODE: begin
                cle = 1'b1;
                we  = 1'b1;
                dq  = OP_DATA_OUT;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nand_page_read_seq.sv
// Module: nand_page_read_seq
// Sequences the command phase of one NAND page read:
// wait ready, setup, address, confirm, wait done, optional ECC status check,
// and read-mode restore.
// Assumes: one bus cycle per phase; a status byte is valid on nf_dq_in in the
// read-strobe cycle.
module nand_page_read_seq import nrs_pkg::*; #(
    parameter int COL_W     = 16,
    parameter int ROW_BYTES = 3,
    parameter int IV_W      = 8,
    parameter int TO_W      = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [ROW_BYTES*8-1:0] page_idx,
    input  logic                   poll_mode,
    input  logic                   ecc_chk,
    input  logic                   multi_plane,
    input  logic [IV_W-1:0]        poll_gap,
    input  logic [TO_W-1:0]        wait_limit,
    output logic                   busy,
    output logic                   done,
    output logic [1:0]             err_code,
    output logic                   nf_cle,
    output logic                   nf_ale,
    output logic                   nf_we,
    output logic                   nf_re,
    output logic [7:0]             nf_dq_out,
    input  logic [7:0]             nf_dq_in,
    input  logic                   nf_ready
);
    localparam int COL_BYTES  = (COL_W + 7) / 8;
    localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
    localparam int IDX_W      = $clog2(ADDR_BYTES + 1);
    localparam int PAGE_W     = ROW_BYTES * 8;

    seq_state_t       st;
    wait_stage_t      stg;
    logic [IDX_W-1:0] idx;
    logic [PAGE_W-1:0] page_q;
    logic             poll_q, ecc_q, multi_q, ecc_bad;
    logic [IV_W-1:0]  gap_q;
    logic [TO_W-1:0]  lim_q;
    logic [7:0]       setup_byte, row_byte;
    logic             to_hit, gap_done, waiting, to_clr, gap_load;
    logic             rdy_bit, fail_bit;

    assign busy     = (st != S_IDLE);
    assign rdy_bit  = nf_dq_in[SR_RDY_BIT];
    assign fail_bit = nf_dq_in[SR_FAIL_BIT];

    // Flag the states in which the device is waited on (timeout applies).
    always_comb begin
        waiting = 1'b0;
        case (st)
            S_PRE_RB, S_POST_RB, S_STAT_CMD, S_STAT_ADDR, S_STAT_RD, S_GAP:
                waiting = (stg != STG_ECC);
            default: waiting = 1'b0;
        endcase
    end

    assign to_clr   = (st == S_IDLE && start) || (st == S_CONF);
    assign gap_load = (st == S_STAT_RD) && (stg != STG_ECC) && !rdy_bit;

    nrs_addr_bytes #(
        .COL_W(COL_W), .ROW_BYTES(ROW_BYTES), .IDX_W(IDX_W)
    ) i_addr (
        .page(page_q), .idx(idx),
        .setup_byte(setup_byte), .row_byte(row_byte)
    );

    nrs_wait_timer #(.IV_W(IV_W), .TO_W(TO_W)) i_timer (
        .clk(clk), .rst_n(rst_n),
        .to_clr(to_clr), .to_run(waiting), .to_lim(lim_q), .to_hit(to_hit),
        .gap_load(gap_load), .gap_val(gap_q), .gap_done(gap_done)
    );

    nrs_bus_decode i_bus (
        .st(st), .multi(multi_q),
        .setup_byte(setup_byte), .row_byte(row_byte),
        .cle(nf_cle), .ale(nf_ale), .we(nf_we), .re(nf_re), .dq(nf_dq_out)
    );

    // Main sequencer: state, stage, byte index, captured request and result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            stg      <= STG_PRE;
            idx      <= '0;
            page_q   <= '0;
            poll_q   <= 1'b0;
            ecc_q    <= 1'b0;
            multi_q  <= 1'b0;
            gap_q    <= '0;
            lim_q    <= '0;
            ecc_bad  <= 1'b0;
            done     <= 1'b0;
            err_code <= ERR_NONE;
        end else begin
            done <= 1'b0;
            if (waiting && to_hit) begin
                st       <= S_IDLE;
                done     <= 1'b1;
                err_code <= ERR_TIMEOUT;
            end else begin
                case (st)
                    S_IDLE: if (start) begin
                        page_q  <= page_idx;
                        poll_q  <= poll_mode;
                        ecc_q   <= ecc_chk;
                        multi_q <= multi_plane;
                        gap_q   <= poll_gap;
                        lim_q   <= wait_limit;
                        stg     <= STG_PRE;
                        ecc_bad <= 1'b0;
                        idx     <= '0;
                        st      <= poll_mode ? S_STAT_CMD : S_PRE_RB;
                    end
                    S_PRE_RB: if (nf_ready) st <= S_SETUP;
                    S_STAT_CMD: begin
                        idx <= '0;
                        st  <= multi_q ? S_STAT_ADDR : S_STAT_RD;
                    end
                    S_STAT_ADDR: begin
                        if (idx == IDX_W'(ROW_BYTES - 1)) begin
                            idx <= '0;
                            st  <= S_STAT_RD;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    S_STAT_RD: begin
                        if (stg == STG_ECC) begin
                            ecc_bad <= fail_bit;
                            st      <= S_MODE;
                        end else if (rdy_bit) begin
                            if (stg == STG_PRE) begin
                                st <= S_SETUP;
                            end else begin
                                ecc_bad <= ecc_q & fail_bit;
                                st      <= S_MODE;
                            end
                        end else begin
                            st <= S_GAP;
                        end
                    end
                    S_GAP: if (gap_done) st <= S_STAT_CMD;
                    S_SETUP: begin
                        idx <= '0;
                        st  <= S_ADDR;
                    end
                    S_ADDR: begin
                        if (idx == IDX_W'(ADDR_BYTES - 1)) begin
                            idx <= '0;
                            st  <= S_CONF;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    S_CONF: begin
                        stg <= STG_POST;
                        st  <= poll_q ? S_STAT_CMD : S_POST_RB;
                    end
                    S_POST_RB: if (nf_ready) begin
                        if (ecc_q) begin
                            stg <= STG_ECC;
                            st  <= S_STAT_CMD;
                        end else begin
                            st       <= S_IDLE;
                            done     <= 1'b1;
                            err_code <= ERR_NONE;
                        end
                    end
                    S_MODE: begin
                        st       <= S_IDLE;
                        done     <= 1'b1;
                        err_code <= ecc_bad ? ERR_ECC : ERR_NONE;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(nf_cle || nf_ale || nf_we || nf_re));

    assert_setup_after_pin_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_cle && nf_we && st == S_SETUP && !poll_q) |-> $past(nf_ready));

    assert_pin_mode_no_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !poll_q && !ecc_q) |->
        !(nf_cle && nf_we && (nf_dq_out == OP_STATUS || nf_dq_out == OP_STATUS_ENH)));

    assert_mode_restore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != ERR_TIMEOUT && (poll_q || ecc_q)) |->
        $past(nf_cle && nf_we && nf_dq_out == OP_DATA_OUT));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_err_only_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != $past(err_code)) |-> done);

endmodule

// File: tb/test_nand_page_read_seq.sv
`timescale 1ns/1ps
module test_nand_page_read_seq;

    localparam int NV = 8;
    //                              v0        v1        v2        v3        v4        v5        v6        v7
    localparam int VP_POLL [NV] = '{0,        0,        1,        1,        1,        0,        1,        0};
    localparam int VP_ECC  [NV] = '{0,        1,        0,        1,        1,        0,        0,        1};
    localparam int VP_MULT [NV] = '{0,        0,        0,        1,        0,        0,        1,        1};
    localparam int VP_PAGE [NV] = '{'h000123, 'h00ABCD, 'h012345, 'hFEDCBA, 'h000001, 'h00F00F, 'h345678, 'h7F0001};
    localparam int VP_PRE  [NV] = '{0,        4,        3,        0,        5,        0,        0,        2};
    localparam int VP_POST [NV] = '{5,        7,        12,       20,       6,        100000,   100000,   3};
    localparam int VP_FAIL [NV] = '{0,        1,        1,        0,        1,        0,        0,        0};
    localparam int VP_GAP  [NV] = '{0,        0,        2,        1,        3,        0,        4,        0};
    localparam int VP_LIM  [NV] = '{1000,     1000,     1000,     1000,     1000,     40,       60,       1000};
    localparam int VP_EXP  [NV] = '{0,        2,        0,        0,        2,        1,        1,        0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] page_idx = '0;
    logic        poll_mode = 1'b0, ecc_chk = 1'b0, multi_plane = 1'b0;
    logic [7:0]  poll_gap = '0;
    logic [19:0] wait_limit = '0;
    logic        busy, done;
    logic [1:0]  err_code;
    logic        nf_cle, nf_ale, nf_we, nf_re, nf_ready;
    logic [7:0]  nf_dq_out, nf_dq_in;

    int n_chk = 0;
    int n_fail = 0;

    // device model controls
    logic        dev_clear = 1'b0;
    int          dev_pre = 0, dev_post = 0;
    logic        dev_fail = 1'b0;

    // device model state
    logic [31:0] dev_busy = '0;
    int          cyc = 0;
    int          n_setup, n_conf, n_rmode, n_stat, n_badop, n_viol, n_addr, n_gap;
    int          gmin, gmax, last_rd;
    logic        conf_seen, have_rd, in_srow, stat_out;
    logic [63:0] addr_word;
    logic [23:0] srow_word;
    int          srow_i;

    always #2.5 clk = ~clk;

    assign nf_ready = (dev_busy == 0);
    assign nf_dq_in = {1'b0, (dev_busy == 0), 5'b0, dev_fail};

    nand_page_read_seq i_nand_page_read_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .page_idx(page_idx),
        .poll_mode(poll_mode), .ecc_chk(ecc_chk), .multi_plane(multi_plane),
        .poll_gap(poll_gap), .wait_limit(wait_limit),
        .busy(busy), .done(done), .err_code(err_code),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we(nf_we), .nf_re(nf_re),
        .nf_dq_out(nf_dq_out), .nf_dq_in(nf_dq_in), .nf_ready(nf_ready)
    );

    // Device model: busy timing and a record of every bus cycle.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (dev_clear) begin
            dev_busy <= 32'(dev_pre);
            n_setup <= 0; n_conf <= 0; n_rmode <= 0; n_stat <= 0; n_badop <= 0;
            n_viol <= 0; n_addr <= 0; n_gap <= 0; gmin <= 1000000; gmax <= 0;
            last_rd <= 0; conf_seen <= 1'b0; have_rd <= 1'b0; in_srow <= 1'b0;
            stat_out <= 1'b0; addr_word <= '0; srow_word <= '0; srow_i <= 0;
        end else begin
            if (dev_busy != 0) dev_busy <= dev_busy - 1;
            if (nf_cle && nf_we) begin
                case (nf_dq_out)
                    8'h00: begin
                        if (!conf_seen) begin
                            n_setup <= n_setup + 1;
                            if (dev_busy != 0) n_viol <= n_viol + 1;
                        end else begin
                            n_rmode <= n_rmode + 1;
                        end
                        stat_out <= 1'b0;
                        have_rd  <= 1'b0;
                    end
                    8'h30: begin
                        n_conf    <= n_conf + 1;
                        conf_seen <= 1'b1;
                        dev_busy  <= 32'(dev_post);
                    end
                    8'h70, 8'h78: begin
                        n_stat   <= n_stat + 1;
                        stat_out <= 1'b1;
                        if ((nf_dq_out == 8'h78) != multi_plane) n_badop <= n_badop + 1;
                        in_srow  <= (nf_dq_out == 8'h78);
                        srow_i   <= 0;
                        if (have_rd) begin
                            n_gap <= n_gap + 1;
                            if (cyc - last_rd < gmin) gmin <= cyc - last_rd;
                            if (cyc - last_rd > gmax) gmax <= cyc - last_rd;
                        end
                    end
                    default: n_badop <= n_badop + 1;
                endcase
            end
            if (nf_ale && nf_we) begin
                if (in_srow) begin
                    srow_word[8*srow_i +: 8] <= nf_dq_out;
                    srow_i <= srow_i + 1;
                end else begin
                    addr_word[8*n_addr +: 8] <= nf_dq_out;
                    n_addr <= n_addr + 1;
                end
            end
            if (nf_re) begin
                last_rd <= cyc;
                have_rd <= 1'b1;
                in_srow <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        bit got;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && done == 0 && err_code == 0, "R1", "reset outputs",
            {busy, done, err_code}, 0);
        chk(!(nf_cle || nf_ale || nf_we || nf_re), "R1", "reset strobes",
            {nf_cle, nf_ale, nf_we, nf_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            poll_mode   = VP_POLL[v][0];
            ecc_chk     = VP_ECC[v][0];
            multi_plane = VP_MULT[v][0];
            page_idx    = VP_PAGE[v][23:0];
            poll_gap    = VP_GAP[v][7:0];
            wait_limit  = VP_LIM[v][19:0];
            dev_pre     = VP_PRE[v];
            dev_post    = VP_POST[v];
            dev_fail    = VP_FAIL[v][0];
            dev_clear   = 1'b1;
            @(negedge clk);
            dev_clear = 1'b0;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
            got = 0;
            for (int w = 0; w < 5000; w++) begin
                if (done) begin got = 1; break; end
                @(negedge clk);
            end
            chk(got, "R11", $sformatf("v%0d done seen", v), got, 1);
            chk(err_code == VP_EXP[v][1:0], (VP_EXP[v] == 1) ? "R9" : "R8",
                $sformatf("v%0d err_code", v), err_code, VP_EXP[v]);
            chk(n_setup == 1 && n_conf == 1, "R6", $sformatf("v%0d setup/confirm count", v),
                n_setup * 16 + n_conf, 'h11);
            chk(n_addr == 5 && addr_word == (64'(VP_PAGE[v]) << 16), "R6",
                $sformatf("v%0d address bytes", v), addr_word, 64'(VP_PAGE[v]) << 16);
            chk(n_viol == 0, "R2", $sformatf("v%0d setup while busy", v), n_viol, 0);
            chk(n_badop == 0, "R4", $sformatf("v%0d bad opcode", v), n_badop, 0);
            if (VP_POLL[v] == 0) begin
                chk(n_stat == ((VP_ECC[v] != 0 && VP_EXP[v] != 1) ? 1 : 0), "R3",
                    $sformatf("v%0d status cmds in pin mode", v), n_stat,
                    (VP_ECC[v] != 0 && VP_EXP[v] != 1) ? 1 : 0);
            end else begin
                chk(n_stat >= 2, "R4", $sformatf("v%0d status polls", v), n_stat, 2);
            end
            if (VP_MULT[v] != 0 && n_stat > 0)
                chk(srow_word == VP_PAGE[v][23:0], "R5", $sformatf("v%0d status row bytes", v),
                    srow_word, VP_PAGE[v]);
            if (VP_EXP[v] == 1) begin
                chk(n_rmode == 0, "R9", $sformatf("v%0d read mode after timeout", v), n_rmode, 0);
            end else begin
                chk(n_rmode == ((VP_POLL[v] != 0 || VP_ECC[v] != 0) ? 1 : 0), "R7",
                    $sformatf("v%0d read mode count", v), n_rmode,
                    (VP_POLL[v] != 0 || VP_ECC[v] != 0) ? 1 : 0);
                chk(stat_out == 0, "R7", $sformatf("v%0d left in data output", v), stat_out, 0);
            end
            if (VP_POLL[v] != 0 && n_gap > 0)
                chk(gmin == VP_GAP[v] + 2 && gmax == VP_GAP[v] + 2, "R10",
                    $sformatf("v%0d poll spacing", v), gmin * 1000 + gmax,
                    (VP_GAP[v] + 2) * 1001);
            @(negedge clk);
            chk(!done && !busy, "R11", $sformatf("v%0d done one cycle", v), {done, busy}, 0);
        end

        // R1: reset in the middle of a wait returns to a quiet idle state
        poll_mode = 1'b1; ecc_chk = 1'b0; multi_plane = 1'b0;
        page_idx = 24'h000055; poll_gap = 8'd1; wait_limit = 20'd50000;
        dev_pre = 0; dev_post = 100000; dev_fail = 1'b0;
        dev_clear = 1'b1;
        @(negedge clk);
        dev_clear = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk(busy == 1, "R1", "busy before mid reset", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && err_code == 0, "R1", "mid reset outputs",
            {busy, done, err_code}, 0);
        chk(!(nf_cle || nf_ale || nf_we || nf_re), "R1", "mid reset strobes",
            {nf_cle, nf_ale, nf_we, nf_re}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 0 && !(nf_cle || nf_we), "R1", "idle after reset", {busy, nf_cle, nf_we}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule